// File: doc/BRIEF.md
# Triggered Command Set Engine

This block holds a small number of command sets. Each set carries up to a few address/data commands that software writes over a plain register bus. A per-command enable mask selects which commands run, and a per-set control word arms the set through an ordered handshake. Once armed, the engine sends each enabled command, lowest index first, as a request on a valid/ready port. For each command it records whether the command was issued and whether it has completed.

Some commands need a response. The engine then stalls its request port until the downstream side returns an acknowledge with response data. When every enabled command of a set has completed, the set goes idle and can raise its interrupt. Sets are laid out in the register space at a fixed stride of 672 bytes. The interrupt enable, status and clear words sit at byte offsets 0x00, 0x04 and 0x08, with one bit per set.

Requests follow valid/ready rules. Once `req_valid` is high, the request fields stay unchanged until `req_ready` is seen high at a clock edge. The response input has no back-pressure: a `rsp_valid` pulse is taken in the cycle it arrives and is ignored when no response is owed.

Top module: `cmd_set_engine`

## Requirements
- R1: After reset, `irq` is low and the interrupt enable and status words read 0.
- R2: Set s has its registers at byte offset s*672. Its wait mask is at +0x10, control at +0x14, busy status at +0x18 and enable mask at +0x1C. Command c occupies the 20-byte slot at +0x30+20*c: message word +0, address +4, data +8, status +12, response data +16. Writable fields read back what was written.
- R3: A set starts only when a control write sets bit 24 (trigger) while the stored bit 16 (mode) is already 1 and the stored trigger is 0. A single write that sets both bits while mode was 0 does not start it. Re-arming takes four writes: clear trigger, clear mode, set mode, set trigger.
- R4: A running set sends its enabled commands in ascending index order and skips disabled ones. Each request carries the command's address and data. `req_write` equals message bit 16. `req_resp` is message bit 8 OR-ed with the command's wait-mask bit.
- R5: While `req_valid` is high and `req_ready` is low, `req_valid` and the request fields stay stable.
- R6: After a request with `req_resp` high is accepted, no further request is made until `rsp_valid` arrives. The response data is then stored in that command's response word.
- R7: In a command's status word, bit 8 is set when the command is accepted downstream. Bit 16 is set at the same time if the command needs no response, otherwise when its acknowledge arrives. Both bits are cleared when the set starts.
- R8: The busy status word of a set reads 0 while the set runs and 1 while it is idle.
- R9: One cycle after the last enabled command of a set completes, that set's interrupt status bit is set, but only if its enable bit is 1. A set started with an empty mask finishes the same way. `irq` is the OR of all status bits.
- R10: Writing 1 to a bit of the clear word at 0x08 clears that status bit. Writing 0 leaves it unchanged.
- R11: While a set runs, writes to its command words, enable mask and wait mask are ignored.
- R12: Writing 0 to a set's enable mask clears the message, address, data, status and response words of all its commands.
- R13: When several sets have commands waiting, the lowest-numbered set issues next. A response goes to the set that issued the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr`, combinational |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the downstream side |
| req_addr | output | DW | Request address |
| req_data | output | DW | Request data |
| req_write | output | 1 | Request is a write |
| req_resp | output | 1 | Request needs a response |
| rsp_valid | input | 1 | Response pulse for the outstanding request |
| rsp_data | input | DW | Response data |
| irq | output | 1 | OR of the interrupt status bits |

## Verification
The bench targets several corner cases:
- **Trigger written together with mode.** A design that arms on the combined write would start issuing requests too early.
- **Back-pressure during a request.** A design that re-arbitrates while the request is held would change fields in mid-handshake.
- **Response-required commands.** A design that does not block on them would send the next request before the acknowledge.
- **Masked interrupts, an empty enable mask and writes made while a set runs.** These would show up as a spurious or missing interrupt one cycle off, or as corrupted command words.
- **Two sets running at once.** If priority is wrong, the higher-numbered set would win.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam logic [9:0] OFF_WAIT = 10'h010;
  localparam logic [9:0] OFF_CTRL = 10'h014;
  localparam logic [9:0] OFF_STAT = 10'h018;
  localparam logic [9:0] OFF_EN   = 10'h01C;
  localparam int OFF_CMD0   = 'h30;
  localparam int CMD_STRIDE = 20;
  localparam int SET_STRIDE = 672;
  localparam int K_MSG = 0;
  localparam int K_ADR = 4;
  localparam int K_DAT = 8;
  localparam int K_STS = 12;
  localparam int K_RSP = 16;
  localparam int MODE_BIT  = 16;
  localparam int TRIG_BIT  = 24;
  localparam int RESP_BIT  = 8;
  localparam int WRITE_BIT = 16;
  localparam int ST_ISS    = 8;
  localparam int ST_CMP    = 16;

  function automatic logic [3:0] first_one(input logic [15:0] v);
    first_one = '0;
    for (int i = 15; i >= 0; i--)
      if (v[i]) first_one = 4'(i);
  endfunction

  function automatic logic [9:0] cmd_off(input int c, input int k);
    return 10'(OFF_CMD0 + CMD_STRIDE * c + k);
  endfunction
endpackage

// File: rtl/cse_set.sv
module cse_set
  import cse_pkg::*;
#(
  parameter int NCMD = 4,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [9:0]    off,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          pend,
  output logic [DW-1:0] c_addr,
  output logic [DW-1:0] c_data,
  output logic          c_resp,
  output logic          c_write,
  input  logic          grant,
  input  logic          ack,
  input  logic [DW-1:0] ack_data,
  output logic          done
);
  localparam int CW = $clog2(NCMD);

  logic [DW-1:0]   msg_q [NCMD];
  logic [DW-1:0]   adr_q [NCMD];
  logic [DW-1:0]   dat_q [NCMD];
  logic [DW-1:0]   rsp_q [NCMD];
  logic [NCMD-1:0] en_q, wt_q, iss_q, cmp_q, todo;
  logic            mode_q, trig_q, busy_q, ack_wait;
  logic [CW-1:0]   nxt, cur_q;
  logic            wr_ok, start;

  assign todo    = en_q & ~iss_q;
  assign nxt     = CW'(first_one(16'(todo)));
  assign pend    = busy_q & ~ack_wait & (|todo);
  assign done    = busy_q & ~ack_wait & ~(|todo);
  assign c_addr  = adr_q[nxt];
  assign c_data  = dat_q[nxt];
  assign c_resp  = msg_q[nxt][RESP_BIT] | wt_q[nxt];
  assign c_write = msg_q[nxt][WRITE_BIT];
  assign wr_ok   = wr & ~busy_q;
  assign start   = wr && (off == OFF_CTRL) && !busy_q && mode_q && !trig_q &&
                   wdata[MODE_BIT] && wdata[TRIG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCMD; c++) begin
        msg_q[c] <= '0; adr_q[c] <= '0; dat_q[c] <= '0; rsp_q[c] <= '0;
      end
      en_q <= '0; wt_q <= '0; iss_q <= '0; cmp_q <= '0;
      mode_q <= 1'b0; trig_q <= 1'b0; busy_q <= 1'b0; ack_wait <= 1'b0;
      cur_q <= '0;
    end else begin
      if (wr && off == OFF_CTRL) begin
        mode_q <= wdata[MODE_BIT];
        trig_q <= wdata[TRIG_BIT];
      end
      if (start) begin
        busy_q <= 1'b1;
        iss_q  <= '0;
        cmp_q  <= '0;
      end
      if (wr_ok && off == OFF_WAIT) wt_q <= wdata[NCMD-1:0];
      if (wr_ok && off == OFF_EN) begin
        en_q <= wdata[NCMD-1:0];
        if (wdata[NCMD-1:0] == '0) begin
          for (int c = 0; c < NCMD; c++) begin
            msg_q[c] <= '0; adr_q[c] <= '0; dat_q[c] <= '0; rsp_q[c] <= '0;
          end
          iss_q <= '0;
          cmp_q <= '0;
        end
      end
      for (int c = 0; c < NCMD; c++) begin
        if (wr_ok && off == cmd_off(c, K_MSG)) msg_q[c] <= wdata;
        if (wr_ok && off == cmd_off(c, K_ADR)) adr_q[c] <= wdata;
        if (wr_ok && off == cmd_off(c, K_DAT)) dat_q[c] <= wdata;
      end
      if (grant) begin
        iss_q[nxt] <= 1'b1;
        if (c_resp) begin
          ack_wait <= 1'b1;
          cur_q    <= nxt;
        end else begin
          cmp_q[nxt] <= 1'b1;
        end
      end
      if (ack && ack_wait) begin
        cmp_q[cur_q] <= 1'b1;
        rsp_q[cur_q] <= ack_data;
        ack_wait     <= 1'b0;
      end
      if (done) busy_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_WAIT: rdata[NCMD-1:0] = wt_q;
      OFF_CTRL: begin
        rdata[MODE_BIT] = mode_q;
        rdata[TRIG_BIT] = trig_q;
      end
      OFF_STAT: rdata[0] = ~busy_q;
      OFF_EN:   rdata[NCMD-1:0] = en_q;
      default:  ;
    endcase
    for (int c = 0; c < NCMD; c++) begin
      if (off == cmd_off(c, K_MSG)) rdata = msg_q[c];
      if (off == cmd_off(c, K_ADR)) rdata = adr_q[c];
      if (off == cmd_off(c, K_DAT)) rdata = dat_q[c];
      if (off == cmd_off(c, K_RSP)) rdata = rsp_q[c];
      if (off == cmd_off(c, K_STS)) begin
        rdata[ST_ISS] = iss_q[c];
        rdata[ST_CMP] = cmp_q[c];
      end
    end
  end
endmodule

// File: rtl/cse_arb.sv
module cse_arb
  import cse_pkg::*;
#(
  parameter int NSETS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSETS-1:0]         pend,
  input  logic                     block,
  input  logic                     accept,
  output logic                     valid,
  output logic [$clog2(NSETS)-1:0] sel
);
  localparam int SW = $clog2(NSETS);

  logic          hold_q;
  logic [SW-1:0] hold_idx, lowest;

  assign lowest = SW'(first_one(16'(pend)));
  assign valid  = ~block & (hold_q | (|pend));
  assign sel    = hold_q ? hold_idx : lowest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      hold_idx <= '0;
    end else begin
      hold_q   <= valid & ~accept;
      hold_idx <= sel;
    end
  end
endmodule

// File: rtl/cmd_set_engine.sv
module cmd_set_engine
  import cse_pkg::*;
#(
  parameter int NSETS = 3,
  parameter int NCMD  = 4,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic          req_write,
  output logic          req_resp,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          irq
);
  localparam int SW = $clog2(NSETS);

  logic [DW-1:0]    s_rdata [NSETS];
  logic [DW-1:0]    s_addr  [NSETS];
  logic [DW-1:0]    s_data  [NSETS];
  logic [9:0]       s_off   [NSETS];
  logic [NSETS-1:0] hit, s_pend, s_resp, s_write, s_done, s_grant, s_ack;
  logic [NSETS-1:0] irq_en_q, irq_st_q;
  logic [SW-1:0]    sel, out_set;
  logic             accept, out_q, com_wr;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    assign hit[s]     = (int'(reg_addr) >= s * SET_STRIDE) &&
                        (int'(reg_addr) < (s + 1) * SET_STRIDE);
    assign s_off[s]   = 10'(int'(reg_addr) - s * SET_STRIDE);
    assign s_grant[s] = accept && (sel == SW'(s));
    assign s_ack[s]   = rsp_valid && out_q && (out_set == SW'(s));

    cse_set #(.NCMD(NCMD), .DW(DW)) u_set (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr & hit[s]), .off(s_off[s]),
      .wdata(reg_wdata), .rdata(s_rdata[s]), .pend(s_pend[s]),
      .c_addr(s_addr[s]), .c_data(s_data[s]), .c_resp(s_resp[s]),
      .c_write(s_write[s]), .grant(s_grant[s]), .ack(s_ack[s]),
      .ack_data(rsp_data), .done(s_done[s])
    );
  end

  cse_arb #(.NSETS(NSETS)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(s_pend), .block(out_q),
    .accept(req_ready), .valid(req_valid), .sel(sel)
  );

  assign req_addr  = s_addr[sel];
  assign req_data  = s_data[sel];
  assign req_resp  = s_resp[sel];
  assign req_write = s_write[sel];
  assign accept    = req_valid & req_ready;
  assign com_wr    = reg_wr && (int'(reg_addr) < 'h10);
  assign irq       = |irq_st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= 1'b0;
      out_set  <= '0;
      irq_en_q <= '0;
      irq_st_q <= '0;
    end else begin
      if (accept && req_resp) begin
        out_q   <= 1'b1;
        out_set <= sel;
      end else if (rsp_valid && out_q) begin
        out_q <= 1'b0;
      end
      if (com_wr && reg_addr == AW'('h0)) irq_en_q <= reg_wdata[NSETS-1:0];
      if (com_wr && reg_addr == AW'('h8))
        irq_st_q <= (irq_st_q & ~reg_wdata[NSETS-1:0]) | (s_done & irq_en_q);
      else
        irq_st_q <= irq_st_q | (s_done & irq_en_q);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'('h0)) reg_rdata[NSETS-1:0] = irq_en_q;
    if (reg_addr == AW'('h4)) reg_rdata[NSETS-1:0] = irq_st_q;
    for (int s = 0; s < NSETS; s++)
      if (hit[s]) reg_rdata = reg_rdata | s_rdata[s];
  end
endmodule

// File: rtl/cse_chk.sv
module cse_chk #(
  parameter int NSETS = 3,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [DW-1:0]    req_addr,
  input logic [DW-1:0]    req_data,
  input logic             req_resp,
  input logic             out_q,
  input logic [NSETS-1:0] irq_en,
  input logic [NSETS-1:0] irq_st
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)); // R5
  AST_RESP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_resp |=> !req_valid); // R6
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !req_valid); // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_st & ~$past(irq_st) & ~$past(irq_en)) == '0)); // R9
endmodule

bind cmd_set_engine cse_chk #(.NSETS(NSETS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_data(req_data), .req_resp(req_resp),
  .out_q(out_q), .irq_en(irq_en_q), .irq_st(irq_st_q)
);

// File: tb/cmd_set_engine_test.sv
module cmd_set_engine_test;
  localparam int NS = 3;
  localparam int NC = 4;
  localparam int STR = 672;
  localparam logic [31:0] KEY = 32'h5A5A_0F0F;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid, req_ready = 0, req_write, req_resp;
  logic [31:0] req_addr, req_data;
  logic rsp_valid = 0;
  logic [31:0] rsp_data = 0;
  logic irq;

  always #4 clk = ~clk;

  cmd_set_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
    .req_write(req_write), .req_resp(req_resp), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq(irq)
  );

  int vecs = 0, miss = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] sh_msg [NS][NC];
  logic [31:0] sh_adr [NS][NC];
  logic [31:0] sh_dat [NS][NC];
  logic [NC-1:0] sh_en [NS];
  logic [NC-1:0] sh_wt [NS];
  bit busy_m [NS];
  bit mode_m [NS];
  bit trig_m [NS];
  bit fin_m [NS];
  bit fin_n [NS];
  logic [NS-1:0] ien_m = 0, ist_m = 0, ist_t;
  bit out_m = 0, held_m = 0;
  int out_s = 0;
  logic [65:0] q [NS][$];
  logic [65:0] e;
  logic [31:0] last_dat = 0;
  int resp_req_cnt = 0;

  initial begin
    for (int s = 0; s < NS; s++) begin
      sh_en[s] = 0; sh_wt[s] = 0;
      busy_m[s] = 0; mode_m[s] = 0; trig_m[s] = 0; fin_m[s] = 0;
      for (int c = 0; c < NC; c++) begin
        sh_msg[s][c] = 0; sh_adr[s][c] = 0; sh_dat[s][c] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int s, a, o, low;
      check(irq == |ist_m, "R9 irq level", 32'(irq), 32'(|ist_m));
      if (out_m) check(!req_valid, "R6 no request while response owed", 32'(req_valid), 0);
      if (req_valid) begin
        s = int'(req_addr[9:8]);
        if (s >= NS || q[s].size() == 0) begin
          check(0, "R4 unexpected request", req_addr, 0);
        end else begin
          e = q[s][0];
          check(req_addr == e[63:32], "R4 address order", req_addr, e[63:32]);
          check(req_data == e[31:0], "R4 data", req_data, e[31:0]);
          check({req_resp, req_write} == e[65:64], "R4 resp/write flags",
                32'({req_resp, req_write}), 32'(e[65:64]));
          if (!held_m) begin
            low = -1;
            for (int k = NS - 1; k >= 0; k--) if (q[k].size() != 0) low = k;
            check(low == s, "R13 lowest set first", 32'(s), 32'(low));
          end
        end
      end
      for (int k = 0; k < NS; k++) fin_n[k] = 0;
      // register writes, evaluated with the current busy state
      if (reg_wr) begin
        a = int'(reg_addr);
        if (a == 0) ien_m = reg_wdata[NS-1:0];
        else if (a >= 16) begin
          s = a / STR; o = a % STR;
          if (o == 'h14) begin
            if (!busy_m[s] && mode_m[s] && !trig_m[s] && reg_wdata[16] && reg_wdata[24]) begin
              busy_m[s] = 1;
              for (int c = 0; c < NC; c++)
                if (sh_en[s][c])
                  q[s].push_back({sh_msg[s][c][8] | sh_wt[s][c], sh_msg[s][c][16],
                                  sh_adr[s][c], sh_dat[s][c]});
              if (q[s].size() == 0) fin_n[s] = 1;
            end
            mode_m[s] = reg_wdata[16]; trig_m[s] = reg_wdata[24];
          end else if (!busy_m[s]) begin
            if (o == 'h10) sh_wt[s] = reg_wdata[NC-1:0];
            if (o == 'h1C) begin
              sh_en[s] = reg_wdata[NC-1:0];
              if (reg_wdata[NC-1:0] == 0)
                for (int c = 0; c < NC; c++) begin
                  sh_msg[s][c] = 0; sh_adr[s][c] = 0; sh_dat[s][c] = 0;
                end
            end
            if (o >= 'h30 && (o - 'h30) / 20 < NC) begin
              if ((o - 'h30) % 20 == 0) sh_msg[s][(o - 'h30) / 20] = reg_wdata;
              if ((o - 'h30) % 20 == 4) sh_adr[s][(o - 'h30) / 20] = reg_wdata;
              if ((o - 'h30) % 20 == 8) sh_dat[s][(o - 'h30) / 20] = reg_wdata;
            end
          end
        end
      end
      ist_t = ist_m;
      if (reg_wr && reg_addr == 12'h8) ist_t = ist_t & ~reg_wdata[NS-1:0];
      for (int k = 0; k < NS; k++)
        if (fin_m[k]) begin
          busy_m[k] = 0;
          if (ien_m[k]) ist_t[k] = 1;
        end
      if (req_valid && req_ready) begin
        s = int'(req_addr[9:8]);
        if (s < NS && q[s].size() != 0) begin
          e = q[s].pop_front();
          if (e[65]) begin
            out_m = 1; out_s = s; last_dat = e[31:0]; resp_req_cnt++;
          end else if (q[s].size() == 0) fin_n[s] = 1;
        end
      end
      if (rsp_valid && out_m) begin
        out_m = 0;
        if (q[out_s].size() == 0) fin_n[out_s] = 1;
      end
      held_m = req_valid && !req_ready;
      for (int k = 0; k < NS; k++) fin_m[k] = fin_n[k];
      ist_m = ist_t;
    end
  end

  // ---------------- downstream responder ----------------
  initial begin
    int seen = 0, dly = 0, cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      req_ready = (cyc % 4 != 1);
      rsp_valid = 0;
      if (resp_req_cnt != seen) begin
        seen = resp_req_cnt; dly = 3;
      end else if (dly > 0) begin
        dly--;
        if (dly == 0) begin
          rsp_valid = 1; rsp_data = last_dat ^ KEY;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [11:0] sa(input int s, input int o);
    return 12'(s * STR + o);
  endfunction
  function automatic logic [11:0] ca(input int s, input int c, input int k);
    return 12'(s * STR + 'h30 + 20 * c + k);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic wait_idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic prog(input int s, input int c, input logic [31:0] m);
    wr(ca(s, c, 0), m);
    wr(ca(s, c, 4), 32'(s << 8) | 32'(c));
    wr(ca(s, c, 8), 32'h1000_0000 + 32'(s * 16 + c));
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    rd_chk(12'h0, 0, "R1 irq enable reset");
    rd_chk(12'h4, 0, "R1 irq status reset");
    check(irq == 0, "R1 irq low", 32'(irq), 0);
    rd_chk(sa(0, 'h18), 1, "R8 idle status after reset");

    wr(12'h0, 32'h3);
    prog(0, 0, 32'h0001_0108);
    prog(0, 1, 32'h0001_0008);
    prog(0, 2, 32'h0001_0008);
    prog(0, 3, 32'h0000_0008);
    wr(sa(0, 'h10), 32'h8);
    wr(sa(0, 'h1C), 32'hB);
    rd_chk(ca(0, 1, 4), 32'h0000_0001, "R2 address readback");
    rd_chk(ca(0, 3, 8), 32'h1000_0003, "R2 data readback");
    rd_chk(sa(0, 'h10), 32'h8, "R2 wait mask readback");
    rd_chk(sa(0, 'h1C), 32'hB, "R2 enable readback");

    wr(sa(0, 'h14), 32'h0101_0000);
    wait_idle(4);
    rd_chk(sa(0, 'h18), 1, "R3 combined write does not start");
    check(req_valid == 0, "R3 no request after combined write", 32'(req_valid), 0);
    rd_chk(sa(0, 'h14), 32'h0101_0000, "R2 control readback");

    wr(sa(0, 'h14), 32'h0001_0000);
    wr(sa(0, 'h14), 32'h0101_0000);
    rd_chk(sa(0, 'h18), 0, "R8 busy reads zero");
    wr(ca(0, 1, 4), 32'hDEAD);
    for (int i = 0; i < 200 && !irq; i++) wait_idle(1);
    rd_chk(ca(0, 1, 4), 32'h0000_0001, "R11 write while busy ignored");
    rd_chk(12'h4, 32'h1, "R9 status bit set for set 0");
    rd_chk(ca(0, 0, 12), 32'h0001_0100, "R7 resp command issued and complete");
    rd_chk(ca(0, 1, 12), 32'h0001_0100, "R7 plain command complete at issue");
    rd_chk(ca(0, 2, 12), 32'h0, "R7 disabled command untouched");
    rd_chk(ca(0, 0, 16), 32'h1000_0000 ^ KEY, "R6 response data stored");
    rd_chk(ca(0, 3, 16), 32'h1000_0003 ^ KEY, "R6 wait-mask response data stored");
    rd_chk(ca(0, 1, 16), 32'h0, "R6 no response word for plain command");

    wr(12'h8, 32'h1);
    #1;
    rd_chk(12'h4, 0, "R10 write-one clears status");
    check(irq == 0, "R10 irq drops", 32'(irq), 0);

    prog(1, 0, 32'h0001_0008);
    prog(1, 1, 32'h0000_0008);
    wr(sa(1, 'h1C), 32'h3);
    prog(2, 0, 32'h0001_0008);
    prog(2, 2, 32'h0001_0108);
    wr(sa(2, 'h1C), 32'h5);
    wr(sa(2, 'h14), 32'h0001_0000);
    wr(sa(1, 'h14), 32'h0001_0000);
    wr(sa(2, 'h14), 32'h0101_0000);
    wr(sa(1, 'h14), 32'h0101_0000);
    wait_idle(60);
    rd_chk(12'h4, 32'h2, "R9 masked set raises no status");
    rd_chk(sa(2, 'h18), 1, "R8 set 2 idle after run");
    rd_chk(ca(2, 2, 16), 32'h1000_0022 ^ KEY, "R13 response routed to issuing set");

    wr(sa(0, 'h14), 32'h0001_0000);
    wr(sa(0, 'h14), 32'h0);
    wr(sa(0, 'h14), 32'h0001_0000);
    wr(sa(0, 'h14), 32'h0101_0000);
    wait_idle(60);
    rd_chk(12'h4, 32'h3, "R3 re-arm sequence runs set 0 again");

    wr(sa(0, 'h1C), 32'h0);
    rd_chk(ca(0, 1, 4), 0, "R12 address discarded");
    rd_chk(ca(0, 0, 0), 0, "R12 message discarded");
    rd_chk(ca(0, 0, 12), 0, "R12 status discarded");
    rd_chk(ca(0, 0, 16), 0, "R12 response discarded");
    wr(12'h8, 32'h7);
    wr(sa(0, 'h14), 32'h0001_0000);
    wr(sa(0, 'h14), 32'h0101_0000);
    wait_idle(3);
    rd_chk(12'h4, 32'h1, "R9 empty mask finishes at once");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule